// File: doc/BRIEF.md
# Cluster Staggered Core-Enable Generator

This block sits beside a cache shared by four cores and runs on the fast cache clock. It emits one single-cycle clock enable per core. Each core is ticked once per frame, and the cores are ticked in different cache cycles. That way each core's cache access lands in a cycle of its own.

A two-bit configuration input selects how many cores run. The frame length follows from that choice. With four or three cores the frame is four cache cycles, so the cache runs four times the core rate. With two cores, or one boosted core, the frame shrinks to two cache cycles, so the cache runs at twice the core rate.

Every core keeps a fixed slot: core i is enabled in slot i of the frame. A core that is off simply receives no enable. A new configuration is adopted only when the current frame ends, so no core ever sees a shortened cycle. Status outputs report the configuration in force and the matching per-core active mask.

Top module: `cluster_phase_clk`

## Requirements
- R1: While reset is held, all core enables are low, the active configuration reads 0 (four cores) and the active mask reads 4'b1111. The first cache cycle after reset release is slot 0 of a four-core frame.
- R2: Configuration 0 (four cores) uses a four-cycle frame. core_en[i] is high exactly in slot i, for i = 0..3, and at most one enable is high in any cycle.
- R3: Configuration 1 (three cores) uses a four-cycle frame. Cores 0, 1 and 2 are enabled in slots 0, 1 and 2. Slot 3 carries no enable.
- R4: Configuration 2 (two cores) uses a two-cycle frame. Cores 0 and 1 are enabled alternately, in slots 0 and 1.
- R5: Configuration 3 (single-core boost) uses a two-cycle frame. Only core 0 is enabled, in slot 0, which means every other cache cycle.
- R6: cfg_mode is sampled only in the last slot of a frame. The sampled value governs the frame that starts in the next cycle. Changes at any other time have no effect on the outputs.
- R7: A core outside the active mask never receives an enable.
- R8: No core's enable is high in two consecutive cache cycles. No core's enable is shortened when the configuration changes.
- R9: active_mask is 4'b1111, 4'b0111, 4'b0011 or 4'b0001 for active configurations 0, 1, 2 and 3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cache clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Requested configuration: 0 four, 1 three, 2 two, 3 one core |
| core_en | output | 4 | Per-core clock enable, one cache cycle wide |
| active_mode | output | 2 | Configuration currently in force |
| active_mask | output | 4 | Cores active under the current configuration |

## Verification
A slot counter that drifts or wraps at the wrong count moves an enable into the wrong cache cycle. That shows up on core_en within one frame, which is two or four cycles. A configuration register that loads mid-frame shows up on active_mode in the very cycle it changes. It also shows as an out-of-place or back-to-back enable in the next cycle. The bench keeps its own frame model and compares all three outputs every cycle, so any such fault is caught within a single frame.

// File: rtl/cluster_phase_clk.sv
module cluster_phase_clk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  output logic [3:0] core_en,
  output logic [1:0] active_mode,
  output logic [3:0] active_mask
);
  localparam int NCORE = 4;
  localparam logic [1:0] CFG_FOUR = 2'd0;
  localparam logic [1:0] CFG_THREE = 2'd1;
  localparam logic [1:0] CFG_TWO = 2'd2;

  logic [1:0] mode_q, slot_q, last_slot;
  logic       run_q;

  assign last_slot   = mode_q[1] ? 2'd1 : 2'd3;
  assign active_mode = mode_q;

  always_comb begin
    case (mode_q)
      CFG_FOUR:  active_mask = 4'b1111;
      CFG_THREE: active_mask = 4'b0111;
      CFG_TWO:   active_mask = 4'b0011;
      default:   active_mask = 4'b0001;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= CFG_FOUR;
      slot_q <= 2'd0;
      run_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (run_q) begin
        if (slot_q == last_slot) begin
          slot_q <= 2'd0;
          mode_q <= cfg_mode;
        end else begin
          slot_q <= slot_q + 2'd1;
        end
      end
    end
  end

  for (genvar i = 0; i < NCORE; i++) begin : g_en
    assign core_en[i] = run_q && active_mask[i] && (slot_q == 2'(i));
  end

  always_ff @(posedge clk)
    if (!rst_n) a_r1_quiet_in_reset: assert (core_en == 4'b0000);

  a_r2_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(core_en));

  a_r7_off_cores_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en & ~active_mask) == 4'b0000);

  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en != 4'b0000) |=> ((core_en & $past(core_en)) == 4'b0000));

  a_r6_frame_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q != last_slot) |=> $stable(active_mode));
endmodule

// File: tb/test_cluster_phase_clk.sv
module test_cluster_phase_clk;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic [3:0] core_en;
  logic [1:0] active_mode;
  logic [3:0] active_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cluster_phase_clk i_cluster_phase_clk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .core_en(core_en), .active_mode(active_mode), .active_mask(active_mask)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] exp_mask(input logic [1:0] m);
    case (m)
      2'd0: return 4'b1111;
      2'd1: return 4'b0111;
      2'd2: return 4'b0011;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic int frame_len(input logic [1:0] m);
    return m[1] ? 2 : 4;
  endfunction

  function automatic logic [3:0] exp_en(input bit run, input logic [1:0] m, input int slot);
    logic [3:0] e = 4'b0000;
    if (run && exp_mask(m)[slot]) e[slot] = 1'b1;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit         m_run = 1'b0;
  logic [1:0] m_mode = 2'd0;
  int         m_slot = 0;
  logic [1:0] cfg_prev = 2'd0;
  logic [3:0] prev_en = 4'b0000;

  task automatic step(input logic [1:0] next_cfg);
    logic [3:0] e;
    string tag;
    @(negedge clk);
    if (!m_run) m_run = 1'b1;
    else if (m_slot == frame_len(m_mode) - 1) begin
      m_slot = 0;
      m_mode = cfg_prev;
    end else m_slot++;
    e = exp_en(m_run, m_mode, m_slot);
    case (m_mode)
      2'd0: tag = "R2";
      2'd1: tag = "R3";
      2'd2: tag = "R4";
      default: tag = "R5";
    endcase
    check(core_en == e, tag, {4'h0, core_en}, {4'h0, e});
    check(active_mode == m_mode, "R6", {6'h0, active_mode}, {6'h0, m_mode});
    check(active_mask == exp_mask(m_mode), "R9", {4'h0, active_mask}, {4'h0, exp_mask(m_mode)});
    check((core_en & ~exp_mask(m_mode)) == 4'b0000, "R7", {4'h0, core_en}, {4'h0, e});
    check((core_en & prev_en) == 4'b0000, "R8", {4'h0, core_en}, {4'h0, prev_en});
    prev_en = core_en;
    cfg_prev = next_cfg;
    cfg_mode = next_cfg;
  endtask

  initial begin
    process::self().srandom(32'd1234);
    rst_n = 1'b0;
    cfg_mode = 2'd3;
    repeat (3) @(negedge clk);
    check(core_en == 4'b0000, "R1", {4'h0, core_en}, 8'h00);
    check(active_mode == 2'd0, "R1", {6'h0, active_mode}, 8'h00);
    check(active_mask == 4'b1111, "R1", {4'h0, active_mask}, 8'h0f);
    cfg_mode = 2'd0;
    cfg_prev = 2'd0;
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 16; k++) step(2'(m));
    end
    for (int k = 0; k < 12; k++) step(2'(k % 4));
    for (int k = 0; k < 40; k++) step(2'(k % 2 ? 3 : 0));
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] c;
      c = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : cfg_prev;
      step(c);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule